// File: doc/BRIEF.md
# Virtual-to-host translation cache

This block keeps recently used address translations so that a requester can turn a virtual address into a physical address and a backing (host) address without going through the slow walker each time. The cache is direct-mapped. Each slot stores the virtual page, the physical page, the backing page address and a copy-on-write flag. A lookup that hits answers one cycle after it is accepted. A lookup that misses stalls the requester, raises a walk request and answers once the walker's fill arrives.

The walker classifies the target of the fill. Ordinary memory and sparse regions are written into the cache. Device windows are answered but are never stored, so every access to a device window goes back to the walker. A fill that finds no target answers with a fault. Both invalidate commands flush every slot. An invalidate that arrives while a fill is pending keeps that fill from being written. Two counters record accepted lookups and misses.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is empty, both counters read 0, `req_ready` is 1, and `resp_valid` and `walk_req` are 0.
- R2: An accepted request whose virtual page matches a valid slot gives `resp_valid` one cycle later, with no walk. `resp_addr` is the stored backing page plus the page offset, and `resp_pa` is the stored physical page joined with the offset.
- R3: On a miss, `walk_req` stays 1 until `fill_valid` is seen, and `walk_vpn`/`walk_write` carry the request's page number and write flag. `req_ready` is 0 while the walk is pending. The response comes one cycle after the fill.
- R4: `fill_kind` 2'b01 (memory): the backing page is `fill_base + (physical page address - fill_phys)`. All flags are 0 and the translation is cached.
- R5: `fill_kind` 2'b10 (sparse): the backing page is `fill_base`, and `resp_cow` follows `fill_cow`. The translation is cached, and later hits report the same copy-on-write flag.
- R6: `fill_kind` 2'b11 (device window): `resp_addr = (fill_dev_id << 24) + (physical address - fill_phys)` and `resp_dev` is 1. The slot is never written, so a repeated access misses again.
- R7: `fill_kind` 2'b00 (no target): `resp_fault` is 1, and `resp_addr` and `resp_pa` are 0. Nothing is cached.
- R8: The slot index is the low log2(DEPTH) bits of the virtual page number. A fill for a different page with the same index evicts the previous page.
- R9: `inv_all` empties every slot at the next edge. `req_ready` is 0 in any cycle in which an invalidate is asserted.
- R10: `inv_tlb` also empties every slot, whatever the value of `inv_tlb_idx`.
- R11: An invalidate seen while a walk is pending still lets that fill produce a response, but the fill is not written into the cache.
- R12: `lookup_cnt` counts accepted requests and `miss_cnt` counts accepted requests that missed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | Access is a write |
| resp_valid | output | 1 | Response strobe |
| resp_addr | output | AW | Backing or device-window address |
| resp_pa | output | AW | Physical address |
| resp_dev | output | 1 | Response is a device window |
| resp_cow | output | 1 | Page is copy-on-write |
| resp_fault | output | 1 | No translation target |
| walk_req | output | 1 | Walk pending |
| walk_vpn | output | VA_W-PAGE_BITS | Virtual page to walk |
| walk_write | output | 1 | Pending access is a write |
| fill_valid | input | 1 | Walker result strobe |
| fill_kind | input | 2 | 00 none, 01 memory, 10 sparse, 11 device window |
| fill_ppn | input | AW-PAGE_BITS | Physical page number |
| fill_base | input | AW | Backing base (memory) or backing page (sparse) |
| fill_phys | input | AW | Physical base of the target region |
| fill_dev_id | input | DEVID_W | Device id for device windows |
| fill_cow | input | 1 | Sparse page is copy-on-write |
| inv_all | input | 1 | Flush all slots |
| inv_tlb | input | 1 | Per-TLB-index invalidate (flushes all) |
| inv_tlb_idx | input | TLB_IDX_W | TLB index of the invalidate |
| lookup_cnt | output | CNT_W | Accepted lookups |
| miss_cnt | output | CNT_W | Misses |

## Verification
A table of accesses first fills a slot from memory and then hits it at a different offset. This separates the stored backing address from the page offset. Sparse pages are read and then written, which shows that the copy-on-write flag is kept across hits. Device windows and faulting pages are each accessed twice: a second miss proves they were never cached. Two pages that share one index tell eviction apart from tag aliasing. Directed sequences then issue both kinds of invalidate and an invalidate that lands inside a pending walk; later accesses show whether each slot was emptied or written.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W        = 32,
  parameter int AW          = 32,
  parameter int PAGE_BITS   = 12,
  parameter int DEPTH       = 64,
  parameter int DEVID_W     = 8,
  parameter int DEVID_SHIFT = 24,
  parameter int TLB_IDX_W   = 6,
  parameter int CNT_W       = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [VA_W-1:0]           req_va,
  input  logic                      req_write,
  output logic                      resp_valid,
  output logic [AW-1:0]             resp_addr,
  output logic [AW-1:0]             resp_pa,
  output logic                      resp_dev,
  output logic                      resp_cow,
  output logic                      resp_fault,
  output logic                      walk_req,
  output logic [VA_W-PAGE_BITS-1:0] walk_vpn,
  output logic                      walk_write,
  input  logic                      fill_valid,
  input  logic [1:0]                fill_kind,
  input  logic [AW-PAGE_BITS-1:0]   fill_ppn,
  input  logic [AW-1:0]             fill_base,
  input  logic [AW-1:0]             fill_phys,
  input  logic [DEVID_W-1:0]        fill_dev_id,
  input  logic                      fill_cow,
  input  logic                      inv_all,
  input  logic                      inv_tlb,
  input  logic [TLB_IDX_W-1:0]      inv_tlb_idx,
  output logic [CNT_W-1:0]          lookup_cnt,
  output logic [CNT_W-1:0]          miss_cnt
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = AW - PAGE_BITS;
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [1:0] K_NONE = 2'b00, K_MEM = 2'b01, K_SPARSE = 2'b10, K_DEV = 2'b11;

  logic [VPN_W:0]   tag_q [DEPTH];
  logic [PPN_W-1:0] ppn_q [DEPTH];
  logic [AW-1:0]    hpa_q [DEPTH];
  logic             cow_q [DEPTH];

  logic            busy_q, drop_q, pend_wr_q;
  logic [VA_W-1:0] pend_va_q;

  logic unused_tlb_idx;
  assign unused_tlb_idx = ^inv_tlb_idx;

  wire             inv      = inv_all | inv_tlb;
  wire [VPN_W-1:0] req_vpn  = req_va[VA_W-1:PAGE_BITS];
  wire [IDX_W-1:0] req_idx  = req_vpn[IDX_W-1:0];
  wire [VPN_W:0]   req_tag  = tag_q[req_idx];
  wire             hit      = !req_tag[VPN_W] && (req_tag[VPN_W-1:0] == req_vpn);
  wire             accept   = req_valid && req_ready;
  wire [AW-1:0]    req_off  = {{PPN_W{1'b0}}, req_va[PAGE_BITS-1:0]};

  wire [VPN_W-1:0] pend_vpn = pend_va_q[VA_W-1:PAGE_BITS];
  wire [IDX_W-1:0] pend_idx = pend_vpn[IDX_W-1:0];
  wire [AW-1:0]    pend_off = {{PPN_W{1'b0}}, pend_va_q[PAGE_BITS-1:0]};
  wire [AW-1:0]    fill_pg  = {fill_ppn, {PAGE_BITS{1'b0}}};
  wire [AW-1:0]    fill_pa  = fill_pg | pend_off;
  wire [AW-1:0]    fill_hpa = (fill_kind == K_SPARSE) ? fill_base : fill_base + (fill_pg - fill_phys);
  wire [AW-1:0]    dev_addr = (AW'(fill_dev_id) << DEVID_SHIFT) + (fill_pa - fill_phys);
  wire             cacheable = (fill_kind == K_MEM) || (fill_kind == K_SPARSE);

  assign req_ready  = !busy_q && !inv;
  assign walk_req   = busy_q;
  assign walk_vpn   = pend_vpn;
  assign walk_write = pend_wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      drop_q     <= 1'b0;
      pend_wr_q  <= 1'b0;
      pend_va_q  <= '0;
      resp_valid <= 1'b0;
      resp_addr  <= '0;
      resp_pa    <= '0;
      resp_dev   <= 1'b0;
      resp_cow   <= 1'b0;
      resp_fault <= 1'b0;
      lookup_cnt <= '0;
      miss_cnt   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '1;
        ppn_q[i] <= '0;
        hpa_q[i] <= '0;
        cow_q[i] <= 1'b0;
      end
    end else begin
      resp_valid <= 1'b0;
      if (accept) begin
        lookup_cnt <= lookup_cnt + 1'b1;
        pend_va_q  <= req_va;
        pend_wr_q  <= req_write;
        if (hit) begin
          resp_valid <= 1'b1;
          resp_addr  <= hpa_q[req_idx] + req_off;
          resp_pa    <= {ppn_q[req_idx], req_va[PAGE_BITS-1:0]};
          resp_dev   <= 1'b0;
          resp_cow   <= cow_q[req_idx];
          resp_fault <= 1'b0;
        end else begin
          busy_q   <= 1'b1;
          drop_q   <= 1'b0;
          miss_cnt <= miss_cnt + 1'b1;
        end
      end
      if (busy_q) begin
        if (inv) drop_q <= 1'b1;
        if (fill_valid) begin
          busy_q     <= 1'b0;
          resp_valid <= 1'b1;
          resp_dev   <= (fill_kind == K_DEV);
          resp_fault <= (fill_kind == K_NONE);
          resp_cow   <= (fill_kind == K_SPARSE) && fill_cow;
          case (fill_kind)
            K_NONE: begin resp_addr <= '0; resp_pa <= '0; end
            K_DEV:  begin resp_addr <= dev_addr; resp_pa <= fill_pa; end
            default: begin resp_addr <= fill_hpa + pend_off; resp_pa <= fill_pa; end
          endcase
          if (cacheable && !drop_q && !inv) begin
            tag_q[pend_idx] <= {1'b0, pend_vpn};
            ppn_q[pend_idx] <= fill_ppn;
            hpa_q[pend_idx] <= fill_hpa;
            cow_q[pend_idx] <= (fill_kind == K_SPARSE) && fill_cow;
          end
        end
      end
      if (inv)
        for (int i = 0; i < DEPTH; i++) tag_q[i] <= '1;
    end
  end

  // R3
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !fill_valid |=> walk_req);
  // R3
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && fill_valid |=> resp_valid && !walk_req);
  // R2
  hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !$past(walk_req) |-> $past(req_valid));
  // R6
  dev_only_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_dev |-> $past(walk_req));
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot0({resp_dev, resp_cow, resp_fault}));
  // R12
  miss_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cnt != $past(miss_cnt) |-> lookup_cnt != $past(lookup_cnt));
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, fill_valid = 0, fill_cow = 0;
  logic inv_all = 0, inv_tlb = 0;
  logic [31:0] req_va = 0, fill_base = 0, fill_phys = 0;
  logic [1:0]  fill_kind = 0;
  logic [19:0] fill_ppn = 0;
  logic [7:0]  fill_dev_id = 0;
  logic [5:0]  inv_tlb_idx = 0;
  logic req_ready, resp_valid, resp_dev, resp_cow, resp_fault, walk_req, walk_write;
  logic [31:0] resp_addr, resp_pa;
  logic [19:0] walk_vpn;
  logic [15:0] lookup_cnt, miss_cnt;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  xlat_cache uut (.*);

  typedef struct packed {
    logic [31:0] va; logic wr; logic [1:0] kind; logic [19:0] ppn;
    logic [31:0] base; logic [31:0] phys; logic [7:0] dev; logic cow;
    logic miss; logic [31:0] addr; logic [31:0] pa; logic [2:0] flg;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{32'h00012345, 1'b0, 2'b01, 20'h00080, 32'h40000000, 32'h00080000, 8'd0, 1'b0, 1'b1, 32'h40000345, 32'h00080345, 3'b000},
    '{32'h00012FFC, 1'b0, 2'b01, 20'h0,     32'h0,        32'h0,        8'd0, 1'b0, 1'b0, 32'h40000FFC, 32'h00080FFC, 3'b000},
    '{32'h00042010, 1'b0, 2'b10, 20'h00123, 32'h70005000, 32'h0,        8'd0, 1'b1, 1'b1, 32'h70005010, 32'h00123010, 3'b010},
    '{32'h00042020, 1'b1, 2'b10, 20'h0,     32'h0,        32'h0,        8'd0, 1'b0, 1'b0, 32'h70005020, 32'h00123020, 3'b010},
    '{32'h00090400, 1'b0, 2'b11, 20'h1F001, 32'h0,        32'h1F000000, 8'd5, 1'b0, 1'b1, 32'h05001400, 32'h1F001400, 3'b100},
    '{32'h00090400, 1'b1, 2'b11, 20'h1F001, 32'h0,        32'h1F000000, 8'd5, 1'b0, 1'b1, 32'h05001400, 32'h1F001400, 3'b100},
    '{32'h00052ABC, 1'b0, 2'b01, 20'h00200, 32'h40000000, 32'h00080000, 8'd0, 1'b0, 1'b1, 32'h40180ABC, 32'h00200ABC, 3'b000},
    '{32'h00012000, 1'b0, 2'b01, 20'h00080, 32'h40000000, 32'h00080000, 8'd0, 1'b0, 1'b1, 32'h40000000, 32'h00080000, 3'b000},
    '{32'h00033000, 1'b0, 2'b00, 20'h0,     32'h0,        32'h0,        8'd0, 1'b0, 1'b1, 32'h0,        32'h0,        3'b001},
    '{32'h00033000, 1'b0, 2'b00, 20'h0,     32'h0,        32'h0,        8'd0, 1'b0, 1'b1, 32'h0,        32'h0,        3'b001}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R4";
      1: return "R2";
      2, 3: return "R5";
      4, 5: return "R6";
      6, 7: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic access(input vec_t v, input string rq);
    @(negedge clk);
    chk("R3", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_va = v.va; req_write = v.wr;
    @(negedge clk);
    req_valid = 0;
    chk(rq, "miss", {31'd0, walk_req}, {31'd0, v.miss});
    if (walk_req) begin
      chk("R3", "walk page", {12'd0, walk_vpn}, {12'd0, v.va[31:12]});
      chk("R3", "walk write", {31'd0, walk_write}, {31'd0, v.wr});
      chk("R3", "ready while walking", {31'd0, req_ready}, 32'd0);
      fill_valid = 1; fill_kind = v.kind; fill_ppn = v.ppn; fill_base = v.base;
      fill_phys = v.phys; fill_dev_id = v.dev; fill_cow = v.cow;
      @(negedge clk);
      fill_valid = 0;
    end
    chk(rq, "resp_valid", {31'd0, resp_valid}, 32'd1);
    chk(rq, "resp_addr", resp_addr, v.addr);
    chk(rq, "resp_pa", resp_pa, v.pa);
    chk(rq, "flags dev/cow/fault", {29'd0, resp_dev, resp_cow, resp_fault}, {29'd0, v.flg});
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R1", "walk_req", {31'd0, walk_req}, 32'd0);
    chk("R1", "lookup_cnt", {16'd0, lookup_cnt}, 32'd0);
    chk("R1", "miss_cnt", {16'd0, miss_cnt}, 32'd0);

    for (int i = 0; i < 10; i++) access(VEC[i], vtag(i));

    // R12 counters: 10 lookups, 8 misses
    chk("R12", "lookup_cnt", {16'd0, lookup_cnt}, 32'd10);
    chk("R12", "miss_cnt", {16'd0, miss_cnt}, 32'd8);

    // R9 full invalidate
    @(negedge clk); inv_all = 1;
    #1 chk("R9", "ready during invalidate", {31'd0, req_ready}, 32'd0);
    @(negedge clk); inv_all = 0;
    access('{32'h00012000, 1'b0, 2'b01, 20'h00080, 32'h40000000, 32'h00080000, 8'd0, 1'b0, 1'b1, 32'h40000000, 32'h00080000, 3'b000}, "R9");
    access('{32'h00012010, 1'b0, 2'b01, 20'h0, 32'h0, 32'h0, 8'd0, 1'b0, 1'b0, 32'h40000010, 32'h00080010, 3'b000}, "R9");

    // R10 per-index invalidate flushes every slot regardless of index
    @(negedge clk); inv_tlb = 1; inv_tlb_idx = 6'h3F;
    @(negedge clk); inv_tlb = 0;
    access('{32'h00012000, 1'b0, 2'b01, 20'h00080, 32'h40000000, 32'h00080000, 8'd0, 1'b0, 1'b1, 32'h40000000, 32'h00080000, 3'b000}, "R10");
    access('{32'h00042010, 1'b0, 2'b10, 20'h00123, 32'h70005000, 32'h0, 8'd0, 1'b0, 1'b1, 32'h70005010, 32'h00123010, 3'b000}, "R10");

    // R11 invalidate during pending walk drops the fill
    @(negedge clk);
    req_valid = 1; req_va = 32'h00060000; req_write = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R11", "miss", {31'd0, walk_req}, 32'd1);
    inv_all = 1;
    @(negedge clk);
    inv_all = 0;
    chk("R11", "still walking", {31'd0, walk_req}, 32'd1);
    fill_valid = 1; fill_kind = 2'b01; fill_ppn = 20'h00300;
    fill_base = 32'h40000000; fill_phys = 32'h00080000; fill_cow = 0;
    @(negedge clk);
    fill_valid = 0;
    chk("R11", "resp_valid", {31'd0, resp_valid}, 32'd1);
    chk("R11", "resp_addr", resp_addr, 32'h40280000);
    access('{32'h00060000, 1'b0, 2'b01, 20'h00300, 32'h40000000, 32'h00080000, 8'd0, 1'b0, 1'b1, 32'h40280000, 32'h00300000, 3'b000}, "R11");
    access('{32'h00060004, 1'b0, 2'b01, 20'h0, 32'h0, 32'h0, 8'd0, 1'b0, 1'b0, 32'h40280004, 32'h00300004, 3'b000}, "R11");

    summary();
    $finish;
  end
endmodule